// File: doc/BRIEF.md
# I2C Channel-Select Switch Controller

This block is the digital half of a four-way I2C bus switch. It listens as a target on a filtered SCL/SDA pair and answers to one 7-bit address. A one-byte write loads a control register in which each bit stands for one downstream channel. A read returns that register. The outputs are four channel-enable signals. They do not follow the register as soon as it is written. They take the new value only when the master ends the transfer with a STOP condition.

Because of this rule, a master that writes the register can read the new value back at once, yet the channels stay as they were. This holds when the master follows the write with a repeated START, and when it leaves the bus parked with SCL low. Only a STOP moves the pending value onto the enables.

The block never drives SCL. SDA is modelled as an open-drain output enable: when `sda_oe` is 1 the pad pulls SDA low. An active-low device reset input and a synchronous system reset both clear the register and the enables.

Top module: `i2c_chansel_switch`

## Requirements
- R1: After system reset, `chan_en` is 0, `sda_oe` is 0, and a read of the control register returns 0x00.
- R2: The address byte 0xE2 (write) or 0xE3 (read), that is address 0x71 with bit 0 as the read flag (1 = read), is acknowledged: `sda_oe` is 1 during the ninth clock.
- R3: A data byte written after an acknowledged write address is acknowledged. Its low four bits are stored, bit i standing for channel i. The upper four bits always read back as 0.
- R4: A data write alone leaves `chan_en` unchanged.
- R5: A STOP that follows one or more accepted writes copies the stored register value onto `chan_en`.
- R6: A repeated START after a write leaves `chan_en` unchanged, and a read in that same transfer returns the pending value.
- R7: Holding SCL low for a long idle period after a write leaves `chan_en` unchanged. The next STOP still commits the value.
- R8: Driving `dev_rst_n` low clears both the control register and `chan_en`.
- R9: `sda_oe` changes only while SCL is low. The block has no SCL output.
- R10: During a read, the target releases SDA for the master's acknowledge bit. On ACK it sends the register again. After a NACK it leaves SDA released until the next START.
- R11: A frame whose address does not match is not acknowledged. Its data bytes are not acknowledged, and it changes neither the register nor `chan_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| srst | input | 1 | Synchronous active-high system reset |
| dev_rst_n | input | 1 | Asynchronous active-low device reset request, synchronized inside |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| chan_en | output | NUM_CH | Committed channel enables, bit i for channel i |

## Verification
The bench tests the pending-versus-committed split from three angles: a write followed by a repeated START and read-back, a write followed by a long SCL-low park, and a normal write and STOP. A design that commits on the write or on a START would show the new channels too early. A design that commits only on a STOP without a prior START would never enable them. Bytes sent to a foreign address must draw NACKs and leave the register alone; a loose address compare would acknowledge them and corrupt the channels. The multi-byte read checks both that an ACK repeats the register and that a NACK releases SDA, so a target that kept driving would read back as a byte other than 0xFF.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } i2cs_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic scl;
    logic sda;
  } bus_evt_t;
endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic srst,
  input  logic line_i,
  output logic line_o
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);
  localparam int SMSB  = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       run_cnt;
  logic                   line_q;

  // metastability chain
  always_ff @(posedge clk) begin
    if (srst) sync_q <= '1;
    else      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end

  // accept a new level only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk) begin
    if (srst) begin
      line_q  <= 1'b1;
      run_cnt <= '0;
    end else if (sync_q[SMSB] == line_q) begin
      run_cnt <= '0;
    end else if (run_cnt == CNT_W'(FILT_LEN - 1)) begin
      line_q  <= sync_q[SMSB];
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + CNT_W'(1);
    end
  end

  assign line_o = line_q;
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events
  import i2cs_pkg::*;
(
  input  logic     clk,
  input  logic     srst,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (srst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    evt.scl   = scl_i;
    evt.sda   = sda_i;
    evt.rise  = scl_i & ~scl_q;
    evt.fall  = ~scl_i & scl_q;
    evt.start = scl_i & scl_q & sda_q & ~sda_i;
    evt.stop  = scl_i & scl_q & ~sda_q & sda_i;
  end
endmodule

// File: rtl/i2cs_byte_engine.sv
module i2cs_byte_engine
  import i2cs_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h71,
  parameter int                CTRL_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_evt_t          evt,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              wr_stb,
  output logic [CTRL_W-1:0] wr_data,
  output logic              sda_oe
);
  localparam int BC_W = $clog2(BYTE_W + 1);

  i2cs_state_e        st;
  logic [BC_W-1:0]    bitcnt;
  logic [BYTE_W-1:0]  shreg;
  logic               rw_flag;
  logic               mst_ack;
  logic               byte_done;

  assign byte_done = (bitcnt == BC_W'(BYTE_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      rw_flag <= 1'b0;
      mst_ack <= 1'b0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (evt.start) begin
        st     <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (evt.stop) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: begin
            if (evt.rise) begin
              shreg  <= {shreg[BYTE_W-2:0], evt.sda};
              bitcnt <= bitcnt + BC_W'(1);
            end else if (evt.fall && byte_done) begin
              if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                rw_flag <= shreg[0];
                sda_oe  <= 1'b1;
                st      <= ST_ADDR_ACK;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (evt.fall) begin
              bitcnt <= '0;
              if (rw_flag) begin
                shreg  <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
                st     <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_WDATA;
              end
            end
          end
          ST_WDATA: begin
            if (evt.rise) begin
              shreg  <= {shreg[BYTE_W-2:0], evt.sda};
              bitcnt <= bitcnt + BC_W'(1);
            end else if (evt.fall && byte_done) begin
              wr_stb  <= 1'b1;
              wr_data <= shreg[CTRL_W-1:0];
              sda_oe  <= 1'b1;
              st      <= ST_WACK;
            end
          end
          ST_WACK: begin
            if (evt.fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              st     <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (evt.rise) begin
              bitcnt <= bitcnt + BC_W'(1);
            end else if (evt.fall) begin
              if (byte_done) begin
                sda_oe <= 1'b0;
                st     <= ST_RACK;
              end else begin
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~shreg[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (evt.rise) begin
              mst_ack <= ~evt.sda;
            end else if (evt.fall) begin
              if (mst_ack) begin
                shreg  <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
                bitcnt <= '0;
                st     <= ST_RDATA;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_SDA_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !evt.scl); // R9
  AST_SKIP_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SKIP) |-> !sda_oe); // R11
  AST_RACK_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RACK) |-> !sda_oe); // R10
endmodule

// File: rtl/i2c_chansel_switch.sv
module i2c_chansel_switch
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h71,
  parameter int         NUM_CH      = 4,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              dev_rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NUM_CH-1:0] chan_en
);
  localparam int NLINES = 2;

  logic [1:0]        rst_sync;
  logic              rst_any;
  logic [NLINES-1:0] raw_lines, clean_lines;
  bus_evt_t          evt;
  logic              wr_stb;
  logic [NUM_CH-1:0] wr_data;
  logic [NUM_CH-1:0] ctrl_q;
  logic              pending;
  logic [BYTE_W-1:0] rd_byte;

  always_ff @(posedge clk) begin
    if (srst) rst_sync <= 2'b11;
    else      rst_sync <= {rst_sync[0], dev_rst_n};
  end
  assign rst_any = srst | ~rst_sync[1];

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2cs_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk   (clk),
      .srst  (srst),
      .line_i(raw_lines[g]),
      .line_o(clean_lines[g])
    );
  end

  i2cs_bus_events u_evt (
    .clk  (clk),
    .srst (rst_any),
    .scl_i(clean_lines[0]),
    .sda_i(clean_lines[1]),
    .evt  (evt)
  );

  assign rd_byte = BYTE_W'(ctrl_q);

  i2cs_byte_engine #(
    .DEV_ADDR(DEV_ADDR),
    .CTRL_W  (NUM_CH)
  ) u_eng (
    .clk    (clk),
    .rst    (rst_any),
    .evt    (evt),
    .rd_byte(rd_byte),
    .wr_stb (wr_stb),
    .wr_data(wr_data),
    .sda_oe (sda_oe)
  );

  // pending register and STOP-gated commit
  always_ff @(posedge clk) begin
    if (rst_any) begin
      ctrl_q  <= '0;
      pending <= 1'b0;
      chan_en <= '0;
    end else if (wr_stb) begin
      ctrl_q  <= wr_data;
      pending <= 1'b1;
    end else if (evt.stop && pending) begin
      chan_en <= ctrl_q;
      pending <= 1'b0;
    end
  end

  AST_DEVRST_CLEAR: assert property (@(posedge clk) disable iff (srst)
    !rst_sync[1] |=> (chan_en == '0 && ctrl_q == '0)); // R8
  AST_EN_HOLD_NO_STOP: assert property (@(posedge clk) disable iff (rst_any)
    !evt.stop |=> $stable(chan_en)); // R6
  AST_WRITE_NO_EN: assert property (@(posedge clk) disable iff (rst_any)
    wr_stb |=> $stable(chan_en)); // R4
  AST_STOP_COMMIT: assert property (@(posedge clk) disable iff (rst_any)
    (evt.stop && pending) |=> (chan_en == $past(ctrl_q))); // R5
endmodule

// File: tb/test_i2c_chansel_switch.sv
module test_i2c_chansel_switch;
  logic       clk = 1'b0;
  logic       srst = 1'b1;
  logic       dev_rst_n = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [3:0] chan_en;
  logic       sda_bus;

  int checks = 0;
  int errors = 0;
  int hi_changes = 0;
  logic sda_prev = 1'b0;
  bit done = 1'b0;

  typedef struct {
    string req;
    string what;
    int    val;
  } item_t;
  item_t exp_q[$];
  int    obs_q[$];

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_chansel_switch i_i2c_chansel_switch (
    .clk      (clk),
    .srst     (srst),
    .dev_rst_n(dev_rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .sda_oe   (sda_oe),
    .chan_en  (chan_en)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_item(input string req, input string what, input int val);
    item_t it;
    it.req = req; it.what = what; it.val = val;
    exp_q.push_back(it);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        item_t it;
        int    v;
        it = exp_q.pop_front();
        v  = obs_q.pop_front();
        check(it.req, it.what, v, it.val);
      end
    end
  end

  // R9: count target SDA changes while the master holds SCL high
  always @(negedge clk) begin
    if (!srst && scl_m && (sda_oe !== sda_prev)) hi_changes++;
    sda_prev = sda_oe;
  end

  task automatic hold();
    repeat (16) @(posedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b0; hold();
    scl_m = 1'b0; hold();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b1; hold();
  endtask

  task automatic send_byte(input logic [7:0] b);
    bit ack;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold();
      scl_m = 1'b1; hold();
      scl_m = 1'b0; hold();
    end
    sda_m = 1'b1; hold();
    scl_m = 1'b1; hold();
    @(negedge clk);
    ack = (sda_bus == 1'b0);
    scl_m = 1'b0; hold();
    obs_q.push_back(int'(ack));
  endtask

  task automatic recv_byte(input bit mack);
    logic [7:0] b;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold();
      scl_m = 1'b1; hold();
      @(negedge clk);
      b[i] = sda_bus;
      scl_m = 1'b0;
    end
    hold();
    sda_m = mack ? 1'b0 : 1'b1; hold();
    scl_m = 1'b1; hold();
    scl_m = 1'b0; hold();
    sda_m = 1'b1;
    obs_q.push_back(int'(b));
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (10) @(posedge clk);
    srst = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R1", "chan_en after reset", int'(chan_en), 0);
    check("R1", "sda_oe after reset", int'(sda_oe), 0);

    // R1/R2: read after reset
    bus_start();
    expect_item("R2", "read address ack", 1); send_byte(8'hE3);
    expect_item("R1", "reset readback", 8'h00); recv_byte(1'b0);
    bus_stop();

    // R3/R4/R5: write 0x01 then STOP
    bus_start();
    expect_item("R2", "write address ack", 1); send_byte(8'hE2);
    expect_item("R3", "data ack", 1); send_byte(8'h01);
    @(negedge clk);
    check("R4", "chan_en before stop", int'(chan_en), 0);
    bus_stop();
    @(negedge clk);
    check("R5", "chan_en after stop", int'(chan_en), 1);

    // R3: channel mapping, bit 2 -> channel 2
    bus_start();
    expect_item("R2", "write address ack", 1); send_byte(8'hE2);
    expect_item("R3", "data ack", 1); send_byte(8'h04);
    bus_stop();
    @(negedge clk);
    check("R3", "channel 2 only", int'(chan_en), 4);

    // R6: write 0xFF, repeated START, read back pending
    bus_start();
    expect_item("R2", "write address ack", 1); send_byte(8'hE2);
    expect_item("R3", "data ack", 1); send_byte(8'hFF);
    bus_start();
    @(negedge clk);
    check("R6", "chan_en after repeated start", int'(chan_en), 4);
    expect_item("R2", "read address ack", 1); send_byte(8'hE3);
    expect_item("R6", "pending readback, upper bits zero (R3)", 8'h0F); recv_byte(1'b0);
    @(negedge clk);
    check("R6", "chan_en after read", int'(chan_en), 4);
    bus_stop();
    @(negedge clk);
    check("R5", "commit after stop", int'(chan_en), 8'h0F);

    // R7: SCL parked low after a write
    bus_start();
    expect_item("R2", "write address ack", 1); send_byte(8'hE2);
    expect_item("R3", "data ack", 1); send_byte(8'h0A);
    repeat (600) @(posedge clk);
    @(negedge clk);
    check("R7", "chan_en while idle low", int'(chan_en), 8'h0F);
    bus_stop();
    @(negedge clk);
    check("R7", "commit on later stop", int'(chan_en), 8'h0A);

    // R11: foreign address
    bus_start();
    expect_item("R11", "foreign address nack", 0); send_byte(8'hE0);
    expect_item("R11", "foreign data nack", 0); send_byte(8'h03);
    bus_stop();
    @(negedge clk);
    check("R11", "chan_en after foreign frame", int'(chan_en), 8'h0A);
    bus_start();
    expect_item("R2", "read address ack", 1); send_byte(8'hE3);
    expect_item("R11", "register untouched", 8'h0A); recv_byte(1'b0);
    bus_stop();

    // R10: ACK repeats, NACK releases
    bus_start();
    expect_item("R2", "read address ack", 1); send_byte(8'hE3);
    expect_item("R10", "first byte", 8'h0A); recv_byte(1'b1);
    expect_item("R10", "repeat after ack", 8'h0A); recv_byte(1'b0);
    @(negedge clk);
    check("R10", "sda released after nack", int'(sda_oe), 0);
    expect_item("R10", "bus idle after nack", 8'hFF); recv_byte(1'b0);
    bus_stop();

    // R8: device reset
    @(negedge clk);
    dev_rst_n = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    dev_rst_n = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R8", "chan_en after device reset", int'(chan_en), 0);
    bus_start();
    expect_item("R2", "read address ack", 1); send_byte(8'hE3);
    expect_item("R8", "register after device reset", 8'h00); recv_byte(1'b0);
    bus_stop();

    repeat (5) @(negedge clk);
    check("R9", "sda_oe changes while SCL high", hi_changes, 0);
    check("R2", "scoreboard leftovers", exp_q.size() + obs_q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule